// File: doc/BRIEF.md
# Pulse Width Capture Unit

The unit times the gap between chosen edges of one asynchronous digital input. Each result is a 16-bit word: a 15-bit duration counted in prescaled clock ticks, plus one bit that gives the input level held during the measured span. Software controls the unit through a small register port. It writes a mode (tick rate, edge pair, one-shot or free-running, overrun policy) and issues commands. It then polls status, or waits for the interrupt line, and reads the result word.

The input first passes through a two-flop synchroniser and then an edge detector. The opening edge of each measurement restarts both the tick divider and the duration counter. The closing edge produces a result. A result is stored, or is dropped because one is already waiting to be read, according to the overrun policy. The unit can take one measurement per start command, or take measurements back to back for as long as it is enabled.

Top module: `pwc_capture`

## Requirements
- R1: After reset, the mode register (addr 1), status register (addr 2), interrupt mask (addr 6) and data register (addr 7) all read 0, and `irq` is low.
- R2: Writing the command register (addr 0) with bit1 enables the unit and with bit2 disables it. Disable wins when both bits are written together. Status bit8 reads 1 while the unit is enabled. Command bit0 is a soft reset that clears the mode, the mask, all flags, the data register and the measurement state.
- R3: With mode bits[5:4]=00, the unit opens on either edge and closes on the opposite edge. Data bit15 is 1 for a high span and 0 for a low span.
- R4: Mode bits[5:4]=10 measure from one rising edge to the next, with bit15=1. Mode bits[5:4]=11 measure from one falling edge to the next, with bit15=0.
- R5: For mode bits[3:0]=N, the duration field (data bits[14:0]) equals floor(W/2^N), where W is the span in clock cycles.
- R6: A span that reaches 0x7FFF ticks before its closing edge sets status bit2 and gives the duration 0x7FFF. Writing 1 to bit2 of the clear-status register (addr 3) clears that flag.
- R7: Every stored result sets status bit3. Reading the data register clears status bit3.
- R8: With mode bit6=0, a result that arrives while status bit3 is set is discarded and status bit1 is set. Writing 1 to bit1 of addr 3 clears status bit1.
- R9: With mode bit6=1, a result that arrives while status bit3 is set replaces the stored data and sets status bit1.
- R10: With mode bit7=1, one measurement is made per start command (command bit3), and further edges are ignored until the next start. A start written while the unit is disabled is ignored.
- R11: With mode bit7=0, the closing edge of one measurement opens the next. In mode 00 this gives alternating high and low results.
- R12: Writing addr 4 sets mask bits and writing addr 5 clears them, using bits 1..3 at the same positions as the status flags. The mask reads back at addr 6. `irq` is high when any flag is set and its mask bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_in | input | 1 | Asynchronous signal being measured |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench targets the prescaler phase. A divider that is not restarted at the opening edge returns durations that are off by one tick, depending on where the divider happened to be. It also checks that the level bit follows the opening edge in each mode: a design that latches the pin level at the closing edge reports the inverse level. The test of the two overrun policies sends two results with no read between them. A design that swaps the policies leaves the wrong word in the data register, and one that loses the flag leaves status bit1 clear. A span of over 32767 cycles confirms saturation together with the overflow flag. Starts issued while the unit is disabled, and edges that arrive after a one-shot measurement has finished, must leave the data-captured flag clear.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CMD    = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE   = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd2;
  localparam logic [ADDR_W-1:0] A_STCLR  = 3'd3;
  localparam logic [ADDR_W-1:0] A_IEN    = 3'd4;
  localparam logic [ADDR_W-1:0] A_IDIS   = 3'd5;
  localparam logic [ADDR_W-1:0] A_IMASK  = 3'd6;
  localparam logic [ADDR_W-1:0] A_DATA   = 3'd7;

  localparam int C_SRST  = 0;
  localparam int C_EN    = 1;
  localparam int C_DIS   = 2;
  localparam int C_START = 3;

  localparam int M_OVW = 6;
  localparam int M_ONE = 7;

  localparam int F_OVR = 1;
  localparam int F_OVF = 2;
  localparam int F_CAP = 3;
  localparam int F_ENS = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_MEAS} meas_st_e;
endpackage

// File: rtl/pwc_sync_edge.sv
module pwc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/pwc_prescaler.sv
module pwc_prescaler #(
  parameter int PSC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [PSC_W-1:0] sel,
  output logic             tick_o
);
  localparam int CW = (1 << PSC_W) - 1;

  logic [CW-1:0] pc_q, pc_d;
  logic [CW:0]   pow;
  logic [CW-1:0] lim;

  always_comb begin
    pow    = (CW+1)'(1) << sel;
    lim    = CW'(pow - (CW+1)'(1));
    tick_o = ((pc_q & lim) == lim);
    pc_d   = clr ? '0 : pc_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  // R5: right after a restart a divided tick cannot fire
  a_r5_no_early_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr) && sel != '0 && $past(sel) == sel) |-> !tick_o);
endmodule

// File: rtl/pwc_meas.sv
module pwc_meas
  import pwc_pkg::*;
#(
  parameter int DUR_W = 15,
  parameter int PSC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             en,
  input  logic             oneshot,
  input  logic [1:0]       sel,
  input  logic [PSC_W-1:0] psc,
  input  logic             start,
  input  logic             rise,
  input  logic             fall,
  output logic             res_valid,
  output logic [DUR_W:0]   res_word,
  output logic             ovf_pulse
);
  localparam logic [DUR_W-1:0] CNT_MAX = '1;

  meas_st_e         st_q, st_d;
  logic [DUR_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;
  logic             tick, inc, psc_clr;
  logic             open_edge, close_edge, open_lvl;

  pwc_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (psc_clr),
    .sel   (psc),
    .tick_o(tick)
  );

  always_comb begin
    open_edge  = sel[1] ? (sel[0] ? fall : rise) : (rise | fall);
    open_lvl   = sel[1] ? ~sel[0] : rise;
    close_edge = sel[1] ? (sel[0] ? fall : rise) : (lvl_q ? fall : rise);
    inc        = tick & (cnt_q != CNT_MAX);
    res_word   = {lvl_q, cnt_q + DUR_W'(inc)};
  end

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    lvl_d     = lvl_q;
    res_valid = 1'b0;
    ovf_pulse = 1'b0;
    psc_clr   = 1'b0;
    if (!en) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (!oneshot || start) st_d = ST_ARMED;
        ST_ARMED: if (open_edge) begin
          st_d    = ST_MEAS;
          cnt_d   = '0;
          lvl_d   = open_lvl;
          psc_clr = 1'b1;
        end
        ST_MEAS: begin
          if (close_edge) begin
            res_valid = 1'b1;
            if (oneshot) begin
              st_d = ST_IDLE;
            end else begin
              cnt_d   = '0;
              lvl_d   = sel[1] ? lvl_q : ~lvl_q;
              psc_clr = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + DUR_W'(inc);
            if (inc && cnt_q == CNT_MAX - DUR_W'(1)) ovf_pulse = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (srst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  // R10: a finished one-shot measurement parks the engine
  a_r10_oneshot_parks: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && oneshot && !srst) |=> (st_q == ST_IDLE));
  // R6: the overflow event coincides with the counter pinned at its ceiling
  a_r6_ovf_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse && !srst) |=> (cnt_q == CNT_MAX));
  // R11: a continuous run re-opens immediately with a fresh count
  a_r11_reopen: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !oneshot && !srst) |=> (st_q == ST_MEAS && cnt_q == '0));
endmodule

// File: rtl/pwc_capture.sv
module pwc_capture
  import pwc_pkg::*;
#(
  parameter int DUR_W  = 15,
  parameter int PSC_W  = 4,
  parameter int SYNC_N = 2,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic              irq
);
  localparam int WORD_W = DUR_W + 1;
  localparam int MODE_W = 8;

  logic [1:0] rs_q;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign arst_n = rs_q[1];

  logic              en_q, en_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              ovr_q, ovr_d, ovf_q, ovf_d, cap_q, cap_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic [3:1]        imask_q, imask_d;

  logic wr_cmd, srst, start, rd_data, pending, wr_clr;
  logic rise, fall, res_valid, ovf_pulse;
  logic [WORD_W-1:0] res_word;

  pwc_sync_edge #(.STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (arst_n),
    .din   (cap_in),
    .rise_o(rise),
    .fall_o(fall)
  );

  pwc_meas #(.DUR_W(DUR_W), .PSC_W(PSC_W)) u_meas (
    .clk      (clk),
    .rst_n    (arst_n),
    .srst     (srst),
    .en       (en_q),
    .oneshot  (mode_q[M_ONE]),
    .sel      (mode_q[5:4]),
    .psc      (mode_q[PSC_W-1:0]),
    .start    (start),
    .rise     (rise),
    .fall     (fall),
    .res_valid(res_valid),
    .res_word (res_word),
    .ovf_pulse(ovf_pulse)
  );

  always_comb begin
    wr_cmd  = wr_en && (addr == A_CMD);
    wr_clr  = wr_en && (addr == A_STCLR);
    srst    = wr_cmd && wdata[C_SRST];
    start   = wr_cmd && wdata[C_START] && en_q;
    rd_data = rd_en && (addr == A_DATA);
    pending = cap_q && !rd_data;

    en_d = en_q;
    if (wr_cmd) begin
      if (wdata[C_DIS])     en_d = 1'b0;
      else if (wdata[C_EN]) en_d = 1'b1;
    end

    mode_d = (wr_en && addr == A_MODE) ? wdata[MODE_W-1:0] : mode_q;

    cap_d = res_valid ? 1'b1 : (rd_data ? 1'b0 : cap_q);
    data_d = (res_valid && (!pending || mode_q[M_OVW])) ? res_word : data_q;

    ovr_d = ovr_q;
    if (wr_clr && wdata[F_OVR]) ovr_d = 1'b0;
    if (res_valid && pending)   ovr_d = 1'b1;

    ovf_d = ovf_q;
    if (wr_clr && wdata[F_OVF]) ovf_d = 1'b0;
    if (ovf_pulse)              ovf_d = 1'b1;

    imask_d = imask_q;
    if (wr_en && addr == A_IEN)  imask_d = imask_d | wdata[3:1];
    if (wr_en && addr == A_IDIS) imask_d = imask_d & ~wdata[3:1];
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      en_q    <= 1'b0;
      mode_q  <= '0;
      ovr_q   <= 1'b0;
      ovf_q   <= 1'b0;
      cap_q   <= 1'b0;
      data_q  <= '0;
      imask_q <= '0;
    end else if (srst) begin
      en_q    <= 1'b0;
      mode_q  <= '0;
      ovr_q   <= 1'b0;
      ovf_q   <= 1'b0;
      cap_q   <= 1'b0;
      data_q  <= '0;
      imask_q <= '0;
    end else begin
      en_q    <= en_d;
      mode_q  <= mode_d;
      ovr_q   <= ovr_d;
      ovf_q   <= ovf_d;
      cap_q   <= cap_d;
      data_q  <= data_d;
      imask_q <= imask_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_MODE:  rdata = BUS_W'(mode_q);
      A_STAT: begin
        rdata[F_ENS] = en_q;
        rdata[F_CAP] = cap_q;
        rdata[F_OVF] = ovf_q;
        rdata[F_OVR] = ovr_q;
      end
      A_IMASK: rdata[3:1] = imask_q;
      A_DATA:  rdata = BUS_W'(data_q);
      default: rdata = '0;
    endcase
  end

  assign irq = |({cap_q, ovf_q, ovr_q} & imask_q);

  // R7: the captured flag only rises on a delivered result
  a_r7_cap_from_result: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(cap_q) |-> $past(res_valid));
  // R8: with the keep policy a pending word is not replaced
  a_r8_drop_keeps: assert property (@(posedge clk) disable iff (!arst_n)
    (res_valid && cap_q && !rd_data && !mode_q[M_OVW] && !srst) |=> $stable(data_q));
  // R9: with the replace policy the newest word lands
  a_r9_overwrite: assert property (@(posedge clk) disable iff (!arst_n)
    (res_valid && cap_q && mode_q[M_OVW] && !srst) |=> (data_q == $past(res_word)));
  // R2: a disable command always leaves the unit off
  a_r2_disable: assert property (@(posedge clk) disable iff (!arst_n)
    (wr_cmd && wdata[C_DIS]) |=> !en_q);
  // R6: overflow flag is sticky until cleared
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!arst_n)
    (ovf_q && !srst && !(wr_clr && wdata[F_OVF])) |=> ovf_q);
endmodule

// File: tb/sim_pwc_capture.sv
module sim_pwc_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_in = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwc_capture u0 (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // {mode, idle level, first span, second span, expected data}
  localparam logic [40:0] VECS [8] = '{
    {8'h80, 1'b0, 8'd10, 8'd0,  16'h800A},
    {8'h80, 1'b1, 8'd7,  8'd0,  16'h0007},
    {8'h82, 1'b0, 8'd20, 8'd0,  16'h8005},
    {8'h83, 1'b0, 8'd30, 8'd0,  16'h8003},
    {8'hA0, 1'b0, 8'd6,  8'd9,  16'h800F},
    {8'hB0, 1'b1, 8'd4,  8'd8,  16'h000C},
    {8'hA1, 1'b0, 8'd5,  8'd6,  16'h8005},
    {8'hB4, 1'b1, 8'd40, 8'd40, 16'h0005}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int w);
    cap_in = 1'b1; waitn(w);
    cap_in = 1'b0; waitn(6);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(150000 * 5);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    waitn(3);
    rst_n = 1'b1;
    waitn(4);

    // R1 reset state
    rd(3'd1, v); chk("R1 mode", v, 16'h0000);
    rd(3'd2, v); chk("R1 status", v, 16'h0000);
    rd(3'd6, v); chk("R1 mask", v, 16'h0000);
    rd(3'd7, v); chk("R1 data", v, 16'h0000);
    chk("R1 irq", {15'b0, irq}, 16'h0000);

    // R2 enable / disable priority
    wr(3'd0, 16'h0002); rd(3'd2, v); chk("R2 enabled", v, 16'h0100);
    wr(3'd0, 16'h0006); rd(3'd2, v); chk("R2 disable wins", v, 16'h0000);

    // R3 R4 R5 R10 vector table, one-shot measurements
    for (int i = 0; i < 8; i++) begin
      logic [7:0] md;
      logic idle;
      md = VECS[i][40:33];
      idle = VECS[i][32];
      wr(3'd0, 16'h0001);
      cap_in = idle; waitn(6);
      wr(3'd1, {8'h00, md});
      wr(3'd0, 16'h0002);
      wr(3'd0, 16'h0008);
      waitn(3);
      cap_in = ~idle; waitn(int'(VECS[i][31:24]));
      cap_in = idle;
      if (md[5]) begin
        waitn(int'(VECS[i][23:16]));
        cap_in = ~idle;
      end
      waitn(6);
      rd(3'd2, v); chk("R7 captured set (R3/R4)", v, 16'h0108);
      rd(3'd7, v); chk("R3/R4/R5 data word", v, VECS[i][15:0]);
      rd(3'd2, v); chk("R7 cleared by read", v, 16'h0100);
      cap_in = idle;
    end

    // R11 continuous, alternating high then low
    wr(3'd0, 16'h0001); cap_in = 1'b0; waitn(4);
    wr(3'd1, 16'h0000); wr(3'd0, 16'h0002); waitn(4);
    cap_in = 1'b1; waitn(10);
    cap_in = 1'b0; waitn(4);
    rd(3'd7, v); chk("R11 first high span", v, 16'h800A);
    waitn(6);
    cap_in = 1'b1; waitn(6);
    rd(3'd7, v); chk("R11 following low span", v, 16'h000C);
    wr(3'd0, 16'h0004);

    // R8 keep policy
    wr(3'd0, 16'h0001); cap_in = 1'b0; waitn(4);
    wr(3'd1, 16'h0000); wr(3'd0, 16'h0002); waitn(4);
    cap_in = 1'b1; waitn(10); cap_in = 1'b0; waitn(12); cap_in = 1'b1; waitn(6);
    wr(3'd0, 16'h0004);
    rd(3'd2, v); chk("R8 overrun flagged", v, 16'h000A);
    rd(3'd7, v); chk("R8 first result kept", v, 16'h800A);
    wr(3'd3, 16'h0002);
    rd(3'd2, v); chk("R8 overrun cleared", v, 16'h0000);

    // R9 replace policy
    wr(3'd0, 16'h0001); cap_in = 1'b0; waitn(4);
    wr(3'd1, 16'h0040); wr(3'd0, 16'h0002); waitn(4);
    cap_in = 1'b1; waitn(10); cap_in = 1'b0; waitn(12); cap_in = 1'b1; waitn(6);
    wr(3'd0, 16'h0004);
    rd(3'd2, v); chk("R9 overrun flagged", v, 16'h000A);
    rd(3'd7, v); chk("R9 newer result stored", v, 16'h000C);

    // R6 R12 overflow and interrupt masking
    wr(3'd0, 16'h0001); cap_in = 1'b0; waitn(4);
    wr(3'd1, 16'h0080);
    wr(3'd4, 16'h0004);
    rd(3'd6, v); chk("R12 mask set", v, 16'h0004);
    wr(3'd0, 16'h0002); wr(3'd0, 16'h0008); waitn(3);
    cap_in = 1'b1; waitn(33000);
    rd(3'd2, v); chk("R6 overflow flag", v, 16'h0104);
    chk("R12 irq on masked overflow", {15'b0, irq}, 16'h0001);
    cap_in = 1'b0; waitn(6);
    rd(3'd7, v); chk("R6 saturated duration", v, 16'hFFFF);
    wr(3'd3, 16'h0004);
    rd(3'd2, v); chk("R6 overflow cleared", v, 16'h0100);
    chk("R12 irq low when unmasked flags", {15'b0, irq}, 16'h0000);
    wr(3'd4, 16'h0008); wr(3'd5, 16'h0008);
    rd(3'd6, v); chk("R12 mask clear", v, 16'h0004);

    // R10 start ignored while disabled, and single shot
    wr(3'd0, 16'h0001); cap_in = 1'b0; waitn(4);
    wr(3'd1, 16'h0080);
    wr(3'd0, 16'h0008);
    wr(3'd0, 16'h0002); waitn(3);
    pulse(8);
    rd(3'd2, v); chk("R10 start while disabled ignored", v, 16'h0100);
    wr(3'd0, 16'h0008); waitn(3);
    pulse(9);
    rd(3'd7, v); chk("R10 one measurement", v, 16'h8009);
    pulse(5);
    rd(3'd2, v); chk("R10 no second measurement", v, 16'h0100);
    rd(3'd7, v); chk("R10 data unchanged", v, 16'h8009);

    // R2 soft reset
    wr(3'd4, 16'h0002);
    wr(3'd0, 16'h0001);
    rd(3'd1, v); chk("R2 soft reset mode", v, 16'h0000);
    rd(3'd6, v); chk("R2 soft reset mask", v, 16'h0000);
    rd(3'd2, v); chk("R2 soft reset status", v, 16'h0000);
    rd(3'd7, v); chk("R2 soft reset data", v, 16'h0000);

    finish_run();
  end
endmodule